// File: doc/BRIEF.md
# Bordered Raster Timing Generator

This block produces the horizontal and vertical timing of a video raster. Registers written by software set it up. Each axis passes through six segments in a fixed order: sync, back porch, leading border, active display, trailing border and front porch. Each boundary between segments is a start position held in a register, and each register holds two positions. The block drives the two sync pulses, each with its own polarity. It also drives a display-enable flag, a border flag, and the current pixel and line counts.

Software writes six timing registers and one control register through a simple port. Timing values are copied into working copies only at a frame boundary, so a frame already being drawn keeps its shape. While the generator is stopped, the copies follow the registers at once. Pixel data, border colour and clock generation are handled elsewhere.

Top module: `vid_timing_gen`

## Requirements
- R1: Addresses 0 to 5 are timing registers. 0 to 2 are horizontal and 3 to 5 are vertical. Address 6 is the control word and address 7 reads as zero. Every register reads back all 32 bits written to it, unused bits included.
- R2: Each timing register holds a low field in bits 11:0 and a high field in bits 27:16. Register 0 (or 3) holds the total in the low field and the back-porch start in the high field. Register 1 (or 4) holds the leading-border start in the low field and the display start in the high field. Register 2 (or 5) holds the trailing-border start in the low field and the front-porch start in the high field.
- R3: When running, the pixel counter counts 0 to total−1 and then wraps to 0. The line counter advances by one on each pixel wrap and wraps after its own total−1.
- R4: The horizontal generator runs when control bit 31 is 1 and bit 0 is 0. The vertical generator runs when bit 31 is 1 and bit 2 is 0. A stopped axis holds its counter at 0, and reset leaves both axes stopped.
- R5: A sync output is active while its counter is below the back-porch start. Control bit 1 set makes hsync active-high and clear makes it active-low. Bit 3 does the same for vsync. A stopped axis holds its sync at the inactive level.
- R6: disp_en is 1 only when both axes are running and both counters are at or past the display start and below the trailing-border start.
- R7: bord_en is 1 when both axes are running, both counters are at or past the leading-border start and below the front-porch start, and the position is not in the active region.
- R8: When either axis is stopped, disp_en and bord_en are 0.
- R9: Timing writes made while both axes run take effect on the clock after the last pixel of the last line. While either axis is stopped, they take effect on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| hsync | output | 1 | Horizontal sync, programmable polarity |
| vsync | output | 1 | Vertical sync, programmable polarity |
| disp_en | output | 1 | Active display region |
| bord_en | output | 1 | Border region outside active area |
| pix_x | output | CW | Pixel counter |
| line_y | output | CW | Line counter |

## Verification
A wrong counter or wrong working copy shows at the next clock as a mismatch on pix_x or line_y. After that, it spreads into sync and enable edges at the wrong positions. A working copy that updates mid-frame shows only at the pixel where the old and new boundaries differ. For that reason, every output is compared on every cycle across frames that span a mid-frame write. A stop bit that is misread shows within one clock as a nonzero counter or an active sync.

// File: rtl/vid_timing_gen.sv
module vid_timing_gen #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          hsync,
  output logic          vsync,
  output logic          disp_en,
  output logic          bord_en,
  output logic [CW-1:0] pix_x,
  output logic [CW-1:0] line_y
);
  localparam int NREG = 6;
  localparam int NFLD = 2 * NREG;
  localparam int HI   = 16;
  localparam int B_RUN = 31, B_HSTOP = 0, B_HPOL = 1, B_VSTOP = 2, B_VPOL = 3;

  logic [31:0]        tim_q [NREG];
  logic [31:0]        ctl_q;
  logic [NFLD*CW-1:0] sh_q;
  logic [CW-1:0]      pix_q, line_q;
  logic [CW-1:0]      hf [6];
  logic [CW-1:0]      vf [6];
  logic run_h, run_v, run_all, pix_last, line_last, load;
  logic act_h, act_v, brd_h, brd_v, syn_h, syn_v;

  always_comb
    for (int k = 0; k < 6; k++) begin
      hf[k] = sh_q[k*CW +: CW];
      vf[k] = sh_q[(k+6)*CW +: CW];
    end

  assign run_h     = ctl_q[B_RUN] & ~ctl_q[B_HSTOP];
  assign run_v     = ctl_q[B_RUN] & ~ctl_q[B_VSTOP];
  assign run_all   = run_h & run_v;
  assign pix_last  = pix_q >= hf[0] - CW'(1);
  assign line_last = line_q >= vf[0] - CW'(1);
  assign load      = ~run_all | (pix_last & line_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < NREG; a++) tim_q[a] <= '0;
      ctl_q <= '0;
    end else if (wr_en) begin
      for (int a = 0; a < NREG; a++)
        if (addr == 3'(a)) tim_q[a] <= wdata;
      if (addr == 3'd6) ctl_q <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int a = 0; a < NREG; a++)
      if (addr == 3'(a)) rdata = tim_q[a];
    if (addr == 3'd6) rdata = ctl_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else if (load)
      for (int a = 0; a < NREG; a++) begin
        sh_q[(2*a)*CW +: CW]   <= tim_q[a][CW-1:0];
        sh_q[(2*a+1)*CW +: CW] <= tim_q[a][HI +: CW];
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run_h) pix_q <= '0;
    else                  pix_q <= pix_last ? '0 : pix_q + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run_v)      line_q <= '0;
    else if (run_h && pix_last) line_q <= line_last ? '0 : line_q + CW'(1);
  end

  assign syn_h = run_h & (pix_q < hf[1]);
  assign syn_v = run_v & (line_q < vf[1]);
  assign brd_h = (pix_q >= hf[2]) & (pix_q < hf[5]);
  assign act_h = (pix_q >= hf[3]) & (pix_q < hf[4]);
  assign brd_v = (line_q >= vf[2]) & (line_q < vf[5]);
  assign act_v = (line_q >= vf[3]) & (line_q < vf[4]);

  assign hsync   = syn_h ? ctl_q[B_HPOL] : ~ctl_q[B_HPOL];
  assign vsync   = syn_v ? ctl_q[B_VPOL] : ~ctl_q[B_VPOL];
  assign disp_en = run_all & act_h & act_v;
  assign bord_en = run_all & brd_h & brd_v & ~(act_h & act_v);
  assign pix_x   = pix_q;
  assign line_y  = line_q;

  a_r4_stop_clears_pix: assert property (@(posedge clk) disable iff (!rst_n)
    !run_h |=> pix_q == '0);
  a_r3_line_moves_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run_v && !(run_h && pix_last)) |=> $stable(line_q));
  a_r9_frame_atomic: assert property (@(posedge clk) disable iff (!rst_n)
    (run_all && !(pix_last && line_last)) |=> $stable(sh_q));
  a_r8_idle_no_enables: assert property (@(posedge clk) disable iff (!rst_n)
    !run_all |-> !disp_en && !bord_en);
  a_r7_enables_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(disp_en && bord_en));
endmodule

// File: tb/test_vid_timing_gen.sv
module test_vid_timing_gen;
  localparam int CW = 12;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic hsync, vsync, disp_en, bord_en;
  logic [CW-1:0] pix_x, line_y;
  int n_chk = 0, n_bad = 0;

  logic [31:0] mreg [7];
  int sh [12];
  int mx, my;

  always #10 clk = ~clk;

  vid_timing_gen #(.CW(CW)) i_vid_timing_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .hsync(hsync), .vsync(vsync), .disp_en(disp_en),
    .bord_en(bord_en), .pix_x(pix_x), .line_y(line_y));

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit rh(); return mreg[6][31] && !mreg[6][0]; endfunction
  function automatic bit rv(); return mreg[6][31] && !mreg[6][2]; endfunction

  task automatic model_step(input bit wr, input int a, input logic [31:0] d);
    bit pl, ll, h, v;
    h  = rh(); v = rv();
    pl = mx >= ((sh[0] + 4095) % 4096);
    ll = my >= ((sh[6] + 4095) % 4096);
    if (!(h && v) || (pl && ll))
      for (int r = 0; r < 6; r++) begin
        sh[2*r]   = int'(mreg[r][11:0]);
        sh[2*r+1] = int'(mreg[r][27:16]);
      end
    if (!v) my = 0;
    else if (h && pl) my = ll ? 0 : my + 1;
    if (!h) mx = 0;
    else mx = pl ? 0 : mx + 1;
    if (wr && a < 7) mreg[a] = d;
  endtask

  task automatic tick(input bit wr, input int a, input logic [31:0] d);
    wr_en = wr; addr = 3'(a); wdata = d;
    @(negedge clk);
    model_step(wr, a, d);
    wr_en = 0;
  endtask

  task automatic cmp_all(input string tag);
    bit h, v, ah, av, bh, bv;
    h = rh(); v = rv();
    ah = mx >= sh[3] && mx < sh[4];  av = my >= sh[9] && my < sh[10];
    bh = mx >= sh[2] && mx < sh[5];  bv = my >= sh[8] && my < sh[11];
    chk(tag, "pix_x", 32'(pix_x), 32'(mx));
    chk(tag, "line_y", 32'(line_y), 32'(my));
    chk(tag, "hsync", 32'(hsync), 32'((h && mx < sh[1]) ? mreg[6][1] : !mreg[6][1]));
    chk(tag, "vsync", 32'(vsync), 32'((v && my < sh[7]) ? mreg[6][3] : !mreg[6][3]));
    chk(tag, "disp_en", 32'(disp_en), 32'(h && v && ah && av));
    chk(tag, "bord_en", 32'(bord_en), 32'(h && v && bh && bv && !(ah && av)));
  endtask

  task automatic run(input string tag, input int n);
    for (int i = 0; i < n; i++) begin tick(0, 0, 0); cmp_all(tag); end
  endtask

  task automatic program_std();
    tick(1, 0, {4'h0, 12'd2, 4'h0, 12'd20});
    tick(1, 1, {4'h0, 12'd6, 4'h0, 12'd4});
    tick(1, 2, {4'h0, 12'd16, 4'h0, 12'd14});
    tick(1, 3, {4'h0, 12'd1, 4'h0, 12'd10});
    tick(1, 4, {4'h0, 12'd3, 4'h0, 12'd2});
    tick(1, 5, {4'h0, 12'd8, 4'h0, 12'd7});
  endtask

  task automatic t_reset();
    cmp_all("R4 reset");
    addr = 3'd0; #1; chk("R1 reset", "rdata0", rdata, 32'h0);
    addr = 3'd6; #1; chk("R1 reset", "rdata6", rdata, 32'h0);
  endtask

  task automatic t_readback();
    for (int a = 0; a < 7; a++) tick(1, a, 32'hA5C3_0F00 ^ (32'h1111_1111 * a) ^ 32'hF000_F000);
    for (int a = 0; a < 8; a++) begin
      addr = 3'(a); #1;
      chk("R1 readback", "rdata", rdata, a < 7 ? mreg[a] : 32'h0);
    end
    tick(1, 6, 32'h0);
    cmp_all("R8 idle after readback");
  endtask

  task automatic t_frames_pos();
    program_std();
    tick(1, 6, 32'h8000_000A);
    cmp_all("R4 start");
    run("R2 R3 R5 R6 R7 posedge pol", 420);
  endtask

  task automatic t_frames_neg();
    tick(1, 6, 32'h8000_0000);
    cmp_all("R5 neg pol");
    run("R5 R6 R7 neg pol", 230);
    tick(1, 6, 32'h8000_0002);
    run("R5 mixed pol", 60);
  endtask

  task automatic t_stop_axes();
    tick(1, 6, 32'h8000_0001);
    run("R4 R8 h stopped", 40);
    tick(1, 6, 32'h8000_0004);
    run("R4 R8 v stopped", 60);
    tick(1, 6, 32'h0000_000A);
    run("R4 R8 all stopped", 10);
  endtask

  task automatic t_midframe();
    tick(1, 6, 32'h8000_000A);
    run("R9 before write", 37);
    tick(1, 0, {4'h0, 12'd3, 4'h0, 12'd24});
    tick(1, 2, {4'h0, 12'd20, 4'h0, 12'd18});
    tick(1, 4, {4'h0, 12'd4, 4'h0, 12'd2});
    cmp_all("R9 write");
    run("R9 midframe update", 600);
  endtask

  initial begin
    for (int a = 0; a < 7; a++) mreg[a] = '0;
    for (int k = 0; k < 12; k++) sh[k] = 0;
    mx = 0; my = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_readback();
    t_frames_pos();
    t_frames_neg();
    t_stop_axes();
    t_midframe();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule